// File: doc/BRIEF.md
# PCI Bus Reset Sequencer

This block generates the active-low reset output of a 33 MHz PCI bus. It keeps the bus in reset while system power is not good. Once the power-good input goes active, it releases reset only after a minimum hold time counted in bus clocks. It also accepts a one-clock software hard-reset strobe, which the surrounding logic decodes from a write to the reset control register. Each strobe drives the bus into reset for at least the same minimum time.

Power-good clears every flop asynchronously, so reset reaches the bus without waiting for a clock edge. The power-good input also passes through a two-stage synchronizer before it can start the hold timer. The hold time is the parameter `HOLD_CYCLES`. Its default of 33,000 clocks is 1 ms at 33 MHz, and a bench can shorten it.

Top module: `pci_rst_seq`

## Requirements
- R1: While `pwr_good` is 0, `bus_rst_n` is 0. When `pwr_good` falls, `bus_rst_n` goes to 0 at once, without waiting for a clock edge.
- R2: Call edge 1 the first rising edge of `clk` that samples `pwr_good` at 1. With no software request, `bus_rst_n` rises exactly at edge `HOLD_CYCLES`+2, which allows two edges for the synchronizer.
- R3: If `sw_rst_req` is 1 at a rising edge while `pwr_good` is 1, `bus_rst_n` is 0 after that edge.
- R4: Suppose the last request is sampled at edge e and the power-up delay has already passed. Then `bus_rst_n` stays 0 until edge e+`HOLD_CYCLES` and rises at that edge.
- R5: A request that arrives while reset is already asserted restarts the hold. Release then happens at the later of two edges: `HOLD_CYCLES` edges after the latest request, or the power-up release edge from R2.
- R6: `bus_rst_n` never rises until at least `HOLD_CYCLES` edges have passed since the latest request, or since power-good was first sampled high, whichever came last.
- R7: Once released, `bus_rst_n` stays 1 until a request is sampled or `pwr_good` falls.
- R8: If `pwr_good` falls during a power-up hold or a software pulse, the full power-up delay of R2 starts again from the next time power-good is sampled high.
- R9: The hold time is the parameter `HOLD_CYCLES`, with a default of 33000, which is 1 ms of a 33 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, nominally 33 MHz |
| pwr_good | input | 1 | Power-good, active high, asynchronous; low clears the block |
| sw_rst_req | input | 1 | Software hard-reset strobe, synchronous to `clk` |
| bus_rst_n | output | 1 | Bus reset, active low, driven from a flop |

## Verification
A wrong hold count shows at the port within one hold period. `bus_rst_n` then rises one or more edges away from edge `HOLD_CYCLES`+2 after power-up, or from e+`HOLD_CYCLES` after a request. A failure to reload on a request, or a timer that wraps instead of stopping at zero, shows as an early release or a spurious new reset pulse. A missing synchronizer stage shifts the power-up release by one edge. A reset path that depends on the clock shows as a nonzero `bus_rst_n` immediately after `pwr_good` falls between edges. The bench models the release edge from event counts and compares it with `bus_rst_n` on every clock, so any of these faults is reported in the cycle it first appears.

// File: rtl/pci_rst_pkg.sv
package pci_rst_pkg;

    // Clocks in one millisecond at the nominal 33 MHz bus clock.
    localparam int unsigned CYCLES_PER_MS_33M = 33000;

    // Level of the active-low bus reset.
    typedef enum logic {
        BUS_IN_RESET = 1'b0,
        BUS_RUNNING  = 1'b1
    } bus_level_e;

endpackage

// File: rtl/pgood_sync.sv
module pgood_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (STAGES > 1) begin
            st_d.chain = {st_q.chain[STAGES-2:0], d};
        end else begin
            st_d.chain = STAGES'(d);
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q = st_q.chain[STAGES-1];

    // Each stage carries the previous value of the input (R2).
    p_sync_shift_r2: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.chain[0] |=> st_q.chain[STAGES-1] || (STAGES > 2))
        else $error("p_sync_shift_r2");

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned HOLD_CYCLES = 33000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = HOLD_V;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        st_d.done = (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.cnt  <= HOLD_V;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.done;

    // The count never leaves its range.
    p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!arst_n)
        st_q.cnt <= HOLD_V)
        else $error("p_cnt_bounded_r6");

    // A load restarts the full hold.
    p_reload_full_r5: assert property (@(posedge clk) disable iff (!arst_n)
        load |=> (st_q.cnt == HOLD_V) && !expired)
        else $error("p_reload_full_r5");

    // Once expired, the timer stays expired until the next load.
    p_expired_sticky_r7: assert property (@(posedge clk) disable iff (!arst_n)
        expired && !load |=> expired)
        else $error("p_expired_sticky_r7");

endmodule

// File: rtl/pci_rst_seq.sv
module pci_rst_seq
    import pci_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = CYCLES_PER_MS_33M
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic sw_rst_req,
    output logic bus_rst_n
);
    localparam int unsigned QW = $clog2(HOLD_CYCLES + 3);
    localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES + 2);

    logic pg_synced;
    logic hold_load;
    logic hold_done;

    pgood_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (pwr_good),
        .d      (pwr_good),
        .q      (pg_synced)
    );

    assign hold_load = !pg_synced || sw_rst_req;

    hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .arst_n  (pwr_good),
        .load    (hold_load),
        .expired (hold_done)
    );

    assign bus_rst_n = hold_done ? BUS_RUNNING : BUS_IN_RESET;

    // Edges since the latest trigger, saturating. Used only by the checks.
    logic [QW-1:0] quiet_d, quiet_q;

    always_comb begin
        quiet_d = quiet_q;
        if (sw_rst_req)          quiet_d = '0;
        else if (quiet_q < QMAX) quiet_d = quiet_q + QW'(1);
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) quiet_q <= '0;
        else           quiet_q <= quiet_d;
    end

    p_hold_low_r1: assert property (@(posedge clk)
        !pwr_good |-> !bus_rst_n)
        else $error("p_hold_low_r1");

    p_sw_asserts_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        sw_rst_req |=> !bus_rst_n)
        else $error("p_sw_asserts_r3");

    p_min_width_r6: assert property (@(posedge clk) disable iff (!pwr_good)
        bus_rst_n |-> quiet_q >= QW'(HOLD_CYCLES))
        else $error("p_min_width_r6");

    p_stay_up_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        bus_rst_n && !sw_rst_req |=> bus_rst_n)
        else $error("p_stay_up_r7");

endmodule

// File: tb/pci_rst_seq_tb.sv
module pci_rst_seq_tb;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic pwr_good = 1'b1;
    logic sw_rst_req = 1'b0;
    logic bus_rst_n;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R1";

    pci_rst_seq #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .sw_rst_req (sw_rst_req),
        .bus_rst_n  (bus_rst_n)
    );

    always #2 clk = ~clk;

    // Reference model: edge numbers of the triggers.
    int edge_n = 0;
    int pg_start = -1;
    int last_sw = -1000000;
    logic exp_n = 1'b0;

    always @(posedge clk) begin
        edge_n++;
        if (!pwr_good) begin
            pg_start = -1;
            last_sw = -1000000;
        end else begin
            if (pg_start < 0) pg_start = edge_n;
            if (sw_rst_req) last_sw = edge_n;
        end
        exp_n = (pg_start >= 0) && (edge_n >= pg_start + HOLD + 1)
                && (edge_n >= last_sw + HOLD);
    end

    task automatic check(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s at edge %0d: bus_rst_n=%b expected %b", req, edge_n, act, expv);
        end
    endtask

    // Compare against the model away from the active edge, on every clock.
    always @(negedge clk) begin
        check(tag, bus_rst_n, pwr_good ? exp_n : 1'b0);
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sw_pulse(input int len);
        sw_rst_req = 1'b1;
        cycles(len);
        sw_rst_req = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1 pwr_good = 1'b0;          // R1: asynchronous clear from time zero
        #0.5 check("R1", bus_rst_n, 1'b0);
        tag = "R1";
        cycles(5);

        tag = "R2";                  // power-up release at edge HOLD+2
        pwr_good = 1'b1;
        cycles(HOLD + 6);
        check("R2", bus_rst_n, 1'b1);

        tag = "R7";                  // stays released
        cycles(8);

        tag = "R3";                  // single request, exact pulse width
        sw_pulse(1);
        check("R3", bus_rst_n, 1'b0);
        tag = "R4";
        cycles(HOLD + 4);
        check("R4", bus_rst_n, 1'b1);

        tag = "R5";                  // second request extends the pulse
        sw_pulse(1);
        cycles(7);
        sw_pulse(1);
        cycles(HOLD + 4);
        sw_pulse(3);                 // request held for several edges
        cycles(HOLD + 4);
        check("R5", bus_rst_n, 1'b1);

        tag = "R8";                  // power loss mid-pulse, between edges
        sw_pulse(1);
        cycles(5);
        @(posedge clk);
        #1 pwr_good = 1'b0;
        #0.5 check("R1", bus_rst_n, 1'b0);
        cycles(4);
        pwr_good = 1'b1;
        cycles(1);
        sw_pulse(1);                 // request inside the synchronizer window
        cycles(HOLD - 6);
        sw_pulse(1);                 // request late in the power-up hold
        cycles(HOLD + 4);
        check("R8", bus_rst_n, 1'b1);

        tag = "R6";                  // power loss while released, then again early
        @(posedge clk);
        #1 pwr_good = 1'b0;
        #0.5 check("R1", bus_rst_n, 1'b0);
        cycles(2);
        pwr_good = 1'b1;
        cycles(HOLD / 2);
        pwr_good = 1'b0;
        cycles(2);
        pwr_good = 1'b1;
        cycles(HOLD + 5);
        check("R6", bus_rst_n, 1'b1);

        tag = "R9";
        check("R9", bus_rst_n, 1'b1);
        cycles(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule